// File: doc/BRIEF.md
# Counter-Compare PWM Generator

This block turns a binary duty word into a pulse-width-modulated logic output. A free-running up counter sweeps the full range of the word width. The output is held in a clocked set/clear flag. The flag is set when the counter reaches its top value and cleared when the count equals the duty word. Low-pass filtering the output gives a level that is proportional to the duty word.

An arbitration stage sits between the compare logic and the flag, so that set and clear never act in the same cycle. When both would fire at the top count, set wins. A duty word of all ones therefore keeps the output high for the whole period. The duty word is captured only at the top count, so a new value starts at the beginning of the next period and never shortens or stretches the period in progress. A complemented output and a one-cycle period strobe are also provided.

Top module: `pwm_cmp_gen`

## Requirements
- R1: The counter increments by one every clock and wraps from its maximum (all ones) to zero, giving a period of 2^WIDTH clocks.
- R2: `period_tick` is high for exactly one clock per period, during the cycle in which the count is at its maximum.
- R3: The output goes high in the first cycle of every period (count zero), because the flag is set at the maximum count.
- R4: For a captured duty value D below the maximum, `pwm_out` is high for the D+1 consecutive cycles with count 0 through D, and low for the rest of the period.
- R5: A captured duty value of all ones keeps `pwm_out` high for all 2^WIDTH cycles of the period: set takes priority over clear at the maximum count.
- R6: A captured duty value of zero gives a single-cycle high pulse per period.
- R7: `duty_in` is sampled only in the cycle where `period_tick` is high. Changes at any other time have no effect until the next period begins.
- R8: `pwm_out_n` is always the logical complement of `pwm_out`.
- R9: Synchronous reset clears the count, the captured duty value and the output to zero. The first period after reset is therefore entirely low.
- R10: The set and clear requests to the output flag are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| duty_in | input | WIDTH | Duty word, captured at the end of each period |
| pwm_out | output | 1 | Pulse-width-modulated output |
| pwm_out_n | output | 1 | Complement of pwm_out |
| period_tick | output | 1 | High during the cycle in which the count is at its maximum |

## Verification
The bench builds the block with its default WIDTH of 8. With that width, the bench sweeps all 256 duty values, one full 256-cycle period each, back to back. For every value it checks the high time, the contiguity of the high run, the strobe position and the complement output. The width is small enough that this sweep reaches both edge cases: the all-ones value, where set wins arbitration, and the zero value, which gives a single-cycle pulse. Further periods cover the post-reset period, duty changes made partway through a period, including the cycle just before the capture point, and a reset applied while the output is high.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

    // Action requested of the output flag for the next cycle.
    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2
    } flag_act_e;

    // Encode separate set/clear requests; set has priority.
    function automatic flag_act_e encode_act(input logic set_req, input logic clr_req);
        if (set_req)      return FLAG_SET;
        else if (clr_req) return FLAG_CLEAR;
        else              return FLAG_HOLD;
    endfunction

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] count,
    output logic             at_top
);
    localparam logic [WIDTH-1:0] TOP = '1;

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == TOP) st_d.cnt = '0;
        else                 st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count  = st_q.cnt;
    assign at_top = (st_q.cnt == TOP);

    // R1: wrap at the top, increment otherwise
    assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (count == TOP) |=> (count == '0));
    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
        (count != TOP) |=> (count == $past(count) + 1'b1));
    // R2: strobe lasts one cycle
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
        at_top |=> !at_top);

endmodule

// File: rtl/pwm_match_gate.sv
module pwm_match_gate #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] count,
    input  logic             at_top,
    input  logic [WIDTH-1:0] duty_in,
    output logic             set_req,
    output logic             clr_req
);
    typedef struct packed {
        logic [WIDTH-1:0] duty;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        match;

    always_comb begin
        st_d = st_q;
        if (at_top) st_d.duty = duty_in;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign match   = (count == st_q.duty);
    assign set_req = at_top;
    assign clr_req = match & ~at_top;

    // R7: captured duty only changes at the period boundary
    assert_duty_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !at_top |=> $stable(st_q.duty));
    assert_duty_load_R7: assert property (@(posedge clk) disable iff (rst)
        at_top |=> (st_q.duty == $past(duty_in)));

endmodule

// File: rtl/pwm_out_flag.sv
module pwm_out_flag
    import pwm_cmp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic level
);
    typedef struct packed {
        logic lvl;
    } flag_state_t;

    flag_state_t st_d, st_q;
    flag_act_e   act;

    always_comb begin
        act  = encode_act(set_req, clr_req);
        st_d = st_q;
        case (act)
            FLAG_SET:   st_d.lvl = 1'b1;
            FLAG_CLEAR: st_d.lvl = 1'b0;
            default:    st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign level = st_q.lvl;

    // R10: arbitration upstream never lets both requests through
    assert_no_set_clear_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        !(set_req && clr_req));
    // R3: set drives the output high next cycle
    assert_set_high_R3: assert property (@(posedge clk) disable iff (rst)
        set_req |=> level);
    // R4: clear drives the output low next cycle
    assert_clear_low_R4: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> !level);
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!set_req && !clr_req) |=> $stable(level));

endmodule

// File: rtl/pwm_cmp_gen.sv
module pwm_cmp_gen #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] duty_in,
    output logic             pwm_out,
    output logic             pwm_out_n,
    output logic             period_tick
);
    logic [WIDTH-1:0] count;
    logic             at_top;
    logic             set_req;
    logic             clr_req;
    logic             level;

    pwm_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .count  (count),
        .at_top (at_top)
    );

    pwm_match_gate #(.WIDTH(WIDTH)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .count   (count),
        .at_top  (at_top),
        .duty_in (duty_in),
        .set_req (set_req),
        .clr_req (clr_req)
    );

    pwm_out_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_req (set_req),
        .clr_req (clr_req),
        .level   (level)
    );

    assign pwm_out     = level;
    assign pwm_out_n   = ~level;
    assign period_tick = at_top;

    // R8: complement output
    assert_complement_R8: assert property (@(posedge clk) disable iff (rst)
        pwm_out_n == !pwm_out);
    // R5: with an all-ones duty captured, the output stays high across the wrap
    assert_full_duty_R5: assert property (@(posedge clk) disable iff (rst)
        (period_tick && duty_in == '1 && pwm_out) |=> pwm_out);

endmodule

// File: tb/tb_pwm_cmp_gen.sv
module tb_pwm_cmp_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] duty_in = 8'h00;
    logic       pwm_out, pwm_out_n, period_tick;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_cmp_gen #(.WIDTH(8)) dut (
        .clk         (clk),
        .rst         (rst),
        .duty_in     (duty_in),
        .pwm_out     (pwm_out),
        .pwm_out_n   (pwm_out_n),
        .period_tick (period_tick)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Precondition: at a negedge during the top-count cycle.
    task automatic run_period(input logic [7:0] d_now, input int exp_high,
                              input int chg_at, input logic [7:0] d_late, input string req);
        int high = 0, first_low = -1, gaps = 0, tick_bad = 0, comp_bad = 0, first_s = 0;
        duty_in = d_now;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (i == chg_at) duty_in = d_late;
            if (i == 0) first_s = int'(pwm_out);
            if (pwm_out) begin
                high++;
                if (first_low >= 0) gaps++;
            end else if (first_low < 0) first_low = i;
            if (period_tick != (i == 255)) tick_bad++;
            if (pwm_out_n != !pwm_out) comp_bad++;
        end
        check(high == exp_high, req, "high cycles", high, exp_high);
        check(gaps == 0 && (exp_high == 256 ? first_low == -1 : first_low == exp_high),
              req, "high run start/contiguity (first low index)", first_low, exp_high == 256 ? -1 : exp_high);
        if (exp_high > 0) check(first_s == 1, "R3", "high at count zero", first_s, 1);
        check(tick_bad == 0, "R1 R2", "period_tick misplaced samples", tick_bad, 0);
        check(comp_bad == 0, "R8", "complement mismatches", comp_bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int high;
        duty_in = 8'h80;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(pwm_out == 1'b0, "R9", "pwm_out in reset", int'(pwm_out), 0);
        check(pwm_out_n == 1'b1, "R9", "pwm_out_n in reset", int'(pwm_out_n), 1);
        check(period_tick == 1'b0, "R9", "period_tick in reset", int'(period_tick), 0);
        rst = 1'b0;
        // R9: first period after reset entirely low although duty_in is nonzero
        high = 0;
        for (int i = 0; i < 256; i++) begin
            if (i > 0) @(negedge clk);
            if (pwm_out) high++;
        end
        check(high == 0, "R9", "high cycles in first period", high, 0);
        check(period_tick == 1'b1, "R2", "tick at end of first period", int'(period_tick), 1);

        // R4 R5 R6: full sweep of duty values
        for (int d = 0; d < 256; d++) begin
            if (d == 0)        run_period(8'(d), 1, -1, 8'h00, "R6");
            else if (d == 255) run_period(8'(d), 256, -1, 8'h00, "R5 R10");
            else               run_period(8'(d), d + 1, -1, 8'h00, "R4");
        end

        // R7: mid-period change has no effect until the next period
        run_period(8'h20, 33, 100, 8'hC0, "R7");
        run_period(8'hC0, 193, 254, 8'h05, "R7");
        run_period(8'h05, 6, -1, 8'h00, "R7");

        // R9: reset while output high
        duty_in = 8'hFF;
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b1, "R5", "output high before reset", int'(pwm_out), 1);
        rst = 1'b1;
        @(negedge clk);
        check(pwm_out == 1'b0, "R9", "pwm_out after mid-run reset", int'(pwm_out), 0);
        check(period_tick == 1'b0, "R9", "tick after mid-run reset", int'(period_tick), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule